// File: doc/BRIEF.md
# Integer Execute Unit with Opcode and Function Decode

This block is the combinational execute stage of a small 32-bit load/store processor. Each cycle it receives two register operands, a 16-bit immediate, a 5-bit shift amount and the instruction's 6-bit major opcode and 6-bit function code. From these it produces one 32-bit result. It handles register-register arithmetic, bitwise logic, constant shifts, add-immediate and the address calculation for word loads and stores.

The surrounding pipeline supplies the operands already read from the register file. It writes the result back, or uses it as a memory address. Any opcode or function pattern that the block does not know raises an illegal flag and yields a zero result. The pipeline can then trap or discard the instruction. Branches, memory access and the register file are handled elsewhere.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0x00 and function 0x20 the result is operand A plus operand B, modulo 2^32, with no overflow indication.
- R2: With opcode 0x00 and function 0x22 the result is operand A minus operand B, modulo 2^32.
- R3: With opcode 0x00 and function 0x18 the result is the low 32 bits of the signed product of A and B.
- R4: With opcode 0x00, function 0x24 gives the bitwise AND of A and B, and function 0x25 gives their bitwise OR.
- R5: With opcode 0x00 and function 0x00 the result is A shifted left by the shift amount, filling with zeros. The all-zero pattern (the no-operation encoding) therefore returns A unchanged and is not illegal.
- R6: With opcode 0x00 and function 0x02 the result is A shifted right by the shift amount, filling with zeros.
- R7: Opcode 0x08 returns A plus the immediate sign-extended from bit 15, modulo 2^32.
- R8: Opcodes 0x23 (load word) and 0x2b (store word) both return the effective address, which is A plus the sign-extended immediate. Operand B has no effect on it.
- R9: Any other opcode, or opcode 0x00 with an unlisted function code, drives the illegal flag high and the result to zero. Every listed encoding drives the flag low.
- R10: The shift amount has no effect on operations that are not shifts, and operand B has no effect on shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_opcode | input | 6 | Major opcode of the instruction |
| i_funct | input | 6 | Function code; used when the opcode is 0x00 |
| i_shamt | input | 5 | Shift amount, from instruction bits [10:6] |
| i_op_a | input | 32 | First source operand (base register for loads and stores) |
| i_op_b | input | 32 | Second source operand |
| i_imm | input | 16 | Immediate field, sign-extended inside the block |
| o_result | output | 32 | Operation result or effective address |
| o_illegal | output | 1 | High when the opcode/function pair is not recognised |

## Verification
The hardest case to reach is a collision between encodings. The no-operation pattern and a zero-distance left shift share one code. Unlisted function codes sit next to listed ones under opcode 0x00. A decoder that keys on the wrong field can still look correct on common instructions. The stimulus therefore drives the all-zero word with a non-zero operand A, and neighbouring unlisted function codes. It also drives operations whose unused fields (operand B on shifts and addresses, the shift amount on arithmetic) hold non-zero values. Any leak of an unused field into the result then shows at the output.

// File: rtl/exu_pkg.sv
// Package exu_pkg
// Shared encodings and the internal operation type for the integer execute
// unit. Assumes the fixed 6-bit opcode and 6-bit function code layout.
package exu_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    // Major opcodes
    localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI = 6'h08;
    localparam logic [OPC_W-1:0] OPC_LDW  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STW  = 6'h2b;

    // Function codes under OPC_REG
    localparam logic [FN_W-1:0] FN_SLL = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL = 6'h02;
    localparam logic [FN_W-1:0] FN_MUL = 6'h18;
    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;

    // Internal operation selected by the decoder
    typedef enum logic [3:0] {
        XOP_ADD,
        XOP_SUB,
        XOP_MUL,
        XOP_AND,
        XOP_OR,
        XOP_SHL,
        XOP_SHR,
        XOP_ADDI,
        XOP_ADDR,
        XOP_BAD
    } xop_e;

    // Which result group drives the output
    typedef enum logic [1:0] {
        GRP_SUM,
        GRP_PROD,
        GRP_BITS,
        GRP_SHIFT
    } grp_e;

endpackage

// File: rtl/exu_decode.sv
// Module exu_decode
// Maps the opcode and function code to one internal operation and a result
// group. Assumes the function code matters only when the opcode is OPC_REG.
// An unknown pattern yields XOP_BAD and asserts o_bad.
module exu_decode
    import exu_pkg::*;
(
    input  logic [OPC_W-1:0] i_opcode,
    input  logic [FN_W-1:0]  i_funct,
    output xop_e             o_op,
    output grp_e             o_grp,
    output logic             o_bad
);

    xop_e reg_op;

    // Select the register-register operation from the function code
    always_comb begin
        case (i_funct)
            FN_ADD:  reg_op = XOP_ADD;
            FN_SUB:  reg_op = XOP_SUB;
            FN_MUL:  reg_op = XOP_MUL;
            FN_AND:  reg_op = XOP_AND;
            FN_OR:   reg_op = XOP_OR;
            FN_SLL:  reg_op = XOP_SHL;
            FN_SRL:  reg_op = XOP_SHR;
            default: reg_op = XOP_BAD;
        endcase
    end

    // Select the final operation from the major opcode
    always_comb begin
        case (i_opcode)
            OPC_REG:          o_op = reg_op;
            OPC_ADDI:         o_op = XOP_ADDI;
            OPC_LDW, OPC_STW: o_op = XOP_ADDR;
            default:          o_op = XOP_BAD;
        endcase
    end

    // Group the operation by the unit that produces its result
    always_comb begin
        case (o_op)
            XOP_MUL:         o_grp = GRP_PROD;
            XOP_AND, XOP_OR: o_grp = GRP_BITS;
            XOP_SHL, XOP_SHR: o_grp = GRP_SHIFT;
            default:         o_grp = GRP_SUM;
        endcase
    end

    assign o_bad = (o_op == XOP_BAD);

endmodule

// File: rtl/exu_arith.sv
// Module exu_arith
// One shared adder for add, subtract, add-immediate and address generation,
// and a multiplier that keeps the low DATA_W bits of the product.
// Assumes two's complement and wrap-around; no overflow is reported.
module exu_arith
    import exu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  xop_e              i_op,
    input  logic [DATA_W-1:0] i_a,
    input  logic [DATA_W-1:0] i_b,
    input  logic [IMM_W-1:0]  i_imm,
    output logic [DATA_W-1:0] o_sum,
    output logic [DATA_W-1:0] o_prod
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] addend;
    logic              carry_in;

    assign imm_sx = {{EXT_W{i_imm[IMM_W-1]}}, i_imm};

    // Choose the second adder input and the carry for the operation
    always_comb begin
        case (i_op)
            XOP_SUB: begin
                addend   = ~i_b;
                carry_in = 1'b1;
            end
            XOP_ADDI, XOP_ADDR: begin
                addend   = imm_sx;
                carry_in = 1'b0;
            end
            default: begin
                addend   = i_b;
                carry_in = 1'b0;
            end
        endcase
    end

    // Shared adder; the carry-out is dropped so the sum wraps
    assign o_sum = i_a + addend + {{(DATA_W-1){1'b0}}, carry_in};

    // The low half of a product is the same for signed and unsigned inputs
    assign o_prod = i_a * i_b;

endmodule

// File: rtl/exu_shifter.sv
// Module exu_shifter
// Logarithmic zero-fill shifter. A left shift reverses the bits, shifts right
// and reverses back, so one set of stages serves both directions. Assumes
// DATA_W is a power of two and the distance is below DATA_W.
module exu_shifter #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  i_val,
    input  logic [SHAMT_W-1:0] i_dist,
    input  logic               i_left,
    output logic [DATA_W-1:0]  o_val
);

    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] stage_in;
    logic [DATA_W-1:0] stage [SHAMT_W+1];
    logic [DATA_W-1:0] rev_out;

    // Bit reversal used on both sides of the stages
    for (genvar bit_i = 0; bit_i < DATA_W; bit_i++) begin : g_rev
        assign rev_in[bit_i]  = i_val[DATA_W-1-bit_i];
        assign rev_out[bit_i] = stage[SHAMT_W][DATA_W-1-bit_i];
    end

    assign stage_in = i_left ? rev_in : i_val;
    assign stage[0] = stage_in;

    // One stage per distance bit, each a fixed power-of-two right shift
    for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = i_dist[k] ? (stage[k] >> STEP) : stage[k];
    end

    assign o_val = i_left ? rev_out : stage[SHAMT_W];

endmodule

// File: rtl/exu_bitwise.sv
// Module exu_bitwise
// Bitwise AND or OR of the two operands. Assumes the decoder only routes
// XOP_AND or XOP_OR here; any other operation selects OR.
module exu_bitwise
    import exu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  xop_e              i_op,
    input  logic [DATA_W-1:0] i_a,
    input  logic [DATA_W-1:0] i_b,
    output logic [DATA_W-1:0] o_val
);

    // Pick the bitwise function
    always_comb begin
        if (i_op == XOP_AND) o_val = i_a & i_b;
        else                 o_val = i_a | i_b;
    end

endmodule

// File: rtl/int_exec_unit.sv
// Module int_exec_unit
// Combinational execute unit: decodes opcode/function, runs the arithmetic,
// bitwise and shift units in parallel and selects one result. Assumes the
// caller latches the result; the block holds no state. Unknown encodings
// give o_illegal high and a zero result.
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [5:0]         i_opcode,
    input  logic [5:0]         i_funct,
    input  logic [SHAMT_W-1:0] i_shamt,
    input  logic [DATA_W-1:0]  i_op_a,
    input  logic [DATA_W-1:0]  i_op_b,
    input  logic [IMM_W-1:0]   i_imm,
    output logic [DATA_W-1:0]  o_result,
    output logic               o_illegal
);

    xop_e              op;
    grp_e              grp;
    logic              bad;
    logic [DATA_W-1:0] sum_val;
    logic [DATA_W-1:0] prod_val;
    logic [DATA_W-1:0] bits_val;
    logic [DATA_W-1:0] shift_val;
    logic [DATA_W-1:0] picked;

    exu_decode u_decode (
        .i_opcode (i_opcode),
        .i_funct  (i_funct),
        .o_op     (op),
        .o_grp    (grp),
        .o_bad    (bad)
    );

    exu_arith #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_arith (
        .i_op   (op),
        .i_a    (i_op_a),
        .i_b    (i_op_b),
        .i_imm  (i_imm),
        .o_sum  (sum_val),
        .o_prod (prod_val)
    );

    exu_bitwise #(
        .DATA_W (DATA_W)
    ) u_bitwise (
        .i_op  (op),
        .i_a   (i_op_a),
        .i_b   (i_op_b),
        .o_val (bits_val)
    );

    exu_shifter #(
        .DATA_W  (DATA_W),
        .SHAMT_W (SHAMT_W)
    ) u_shifter (
        .i_val  (i_op_a),
        .i_dist (i_shamt),
        .i_left (op == XOP_SHL),
        .o_val  (shift_val)
    );

    // Route the result of the group the decoder chose
    always_comb begin
        case (grp)
            GRP_PROD:  picked = prod_val;
            GRP_BITS:  picked = bits_val;
            GRP_SHIFT: picked = shift_val;
            default:   picked = sum_val;
        endcase
    end

    // Squash the result of an unknown encoding
    assign o_result  = bad ? '0 : picked;
    assign o_illegal = bad;

endmodule

// File: rtl/exu_exec_chk.sv
// Module exu_exec_chk
// Port-level checks for int_exec_unit. The block is combinational, so the
// checks are immediate assertions evaluated whenever the ports change.
module exu_exec_chk #(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input logic [5:0]         i_opcode,
    input logic [5:0]         i_funct,
    input logic [SHAMT_W-1:0] i_shamt,
    input logic [DATA_W-1:0]  i_op_a,
    input logic [DATA_W-1:0]  i_op_b,
    input logic [IMM_W-1:0]   i_imm,
    input logic [DATA_W-1:0]  o_result,
    input logic               o_illegal
);

    logic [DATA_W-1:0] imm_wide;
    logic              is_reg;

    assign imm_wide = {{(DATA_W-IMM_W){i_imm[IMM_W-1]}}, i_imm};
    assign is_reg   = (i_opcode == 6'h00);

    // Evaluate every port relation on any change
    always_comb begin
        p_illegal_zero_r9: assert (!o_illegal || (o_result == '0))
            else $error("illegal encoding left a non-zero result");
        p_mem_legal_r8: assert (!((i_opcode == 6'h23) || (i_opcode == 6'h2b)) || !o_illegal)
            else $error("load/store opcode flagged illegal");
        p_sub_inverse_r2: assert (!(is_reg && i_funct == 6'h22) || ((o_result + i_op_b) == i_op_a))
            else $error("subtract result plus B does not give A");
        p_addi_offset_r7: assert (!(i_opcode == 6'h08) || ((o_result - i_op_a) == imm_wide))
            else $error("add-immediate offset mismatch");
        p_and_subset_r4: assert (!(is_reg && i_funct == 6'h24) || ((o_result & ~i_op_a) == '0))
            else $error("AND result has bits outside A");
        p_or_superset_r4: assert (!(is_reg && i_funct == 6'h25) || ((o_result & i_op_b) == i_op_b))
            else $error("OR result lacks bits of B");
        p_srl_msb_r6: assert (!(is_reg && i_funct == 6'h02 && i_shamt != '0) || !o_result[DATA_W-1])
            else $error("right shift did not fill with zero");
        p_nop_pass_r5: assert (!(is_reg && i_funct == 6'h00 && i_shamt == '0) || (o_result == i_op_a && !o_illegal))
            else $error("no-operation encoding changed A");
    end

endmodule

bind int_exec_unit exu_exec_chk #(
    .DATA_W  (DATA_W),
    .IMM_W   (IMM_W),
    .SHAMT_W (SHAMT_W)
) i_exec_chk (.*);

// File: tb/test_int_exec_unit.sv
// Directed bench for int_exec_unit: one task per scenario, each checking
// its own results against constants derived from the requirements.
module test_int_exec_unit;

    logic        clk;
    logic        rst_n;
    logic [5:0]  opcode;
    logic [5:0]  funct;
    logic [4:0]  shamt;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [15:0] imm;
    logic [31:0] result;
    logic        illegal;

    int n_checks;
    int n_fails;
    bit done;

    int_exec_unit i_int_exec_unit (
        .i_opcode  (opcode),
        .i_funct   (funct),
        .i_shamt   (shamt),
        .i_op_a    (op_a),
        .i_op_b    (op_b),
        .i_imm     (imm),
        .o_result  (result),
        .o_illegal (illegal)
    );

    // 100 MHz clock
    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Compare one value and log a failure
    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
        end
    endtask

    // Drive one operation on the falling edge and let it settle
    task automatic drive(input logic [5:0] opc, input logic [5:0] fn,
                         input logic [4:0] sh, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] im);
        @(negedge clk);
        opcode = opc; funct = fn; shamt = sh; op_a = a; op_b = b; imm = im;
        #2;
    endtask

    // Drive, then check result and flag
    task automatic run(input string req, input string what,
                       input logic [5:0] opc, input logic [5:0] fn,
                       input logic [4:0] sh, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im,
                       input logic [31:0] exp, input logic exp_ill);
        drive(opc, fn, sh, a, b, im);
        check(req, what, result, exp);
        check(req, {what, " flag"}, {31'd0, illegal}, {31'd0, exp_ill});
    endtask

    task automatic t_reset_state();
        check("R5", "idle result", result, 32'h0);
        check("R9", "idle flag", {31'd0, illegal}, 32'h0);
    endtask

    task automatic t_add_r1();
        run("R1", "add small", 6'h00, 6'h20, 5'd0, 32'd5, 32'd7, 16'h0, 32'd12, 1'b0);
        run("R1", "add wrap", 6'h00, 6'h20, 5'd0, 32'hFFFF_FFFF, 32'd2, 16'h0, 32'd1, 1'b0);
    endtask

    task automatic t_sub_r2();
        run("R2", "sub negative", 6'h00, 6'h22, 5'd0, 32'd3, 32'd5, 16'h0, 32'hFFFF_FFFE, 1'b0);
        run("R2", "sub wrap", 6'h00, 6'h22, 5'd0, 32'h8000_0000, 32'd1, 16'h0, 32'h7FFF_FFFF, 1'b0);
    endtask

    task automatic t_mul_r3();
        run("R3", "mul signed", 6'h00, 6'h18, 5'd0, 32'hFFFF_FFFD, 32'd7, 16'h0, 32'hFFFF_FFEB, 1'b0);
        run("R3", "mul low half", 6'h00, 6'h18, 5'd0, 32'h0001_0000, 32'h0001_0000, 16'h0, 32'h0, 1'b0);
        run("R3", "mul scale", 6'h00, 6'h18, 5'd0, 32'h1234_5678, 32'h10, 16'h0, 32'h2345_6780, 1'b0);
    endtask

    task automatic t_logic_r4();
        run("R4", "and", 6'h00, 6'h24, 5'd0, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 32'h00F0_1200, 1'b0);
        run("R4", "or", 6'h00, 6'h25, 5'd0, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 32'hFFF0_FF34, 1'b0);
    endtask

    task automatic t_sll_r5();
        run("R5", "sll by 1", 6'h00, 6'h00, 5'd1, 32'h8000_0001, 32'h0, 16'h0, 32'h0000_0002, 1'b0);
        run("R5", "sll by 31", 6'h00, 6'h00, 5'd31, 32'h0000_0001, 32'h0, 16'h0, 32'h8000_0000, 1'b0);
        run("R5", "nop keeps A", 6'h00, 6'h00, 5'd0, 32'h0000_1234, 32'h0, 16'h0, 32'h0000_1234, 1'b0);
    endtask

    task automatic t_srl_r6();
        run("R6", "srl by 31", 6'h00, 6'h02, 5'd31, 32'h8000_0000, 32'h0, 16'h0, 32'h1, 1'b0);
        run("R6", "srl by 4", 6'h00, 6'h02, 5'd4, 32'hF000_000F, 32'h0, 16'h0, 32'h0F00_0000, 1'b0);
    endtask

    task automatic t_addi_r7();
        run("R7", "addi minus one", 6'h08, 6'h00, 5'd0, 32'd10, 32'h0, 16'hFFFF, 32'd9, 1'b0);
        run("R7", "addi max positive", 6'h08, 6'h00, 5'd0, 32'd1, 32'h0, 16'h7FFF, 32'h0000_8000, 1'b0);
    endtask

    task automatic t_addr_r8();
        run("R8", "load negative disp", 6'h23, 6'h11, 5'd3, 32'h0000_1000, 32'hDEAD_BEEF, 16'hFFFC, 32'h0000_0FFC, 1'b0);
        run("R8", "store positive disp", 6'h2b, 6'h3F, 5'd9, 32'h0000_2000, 32'hFFFF_FFFF, 16'h0010, 32'h0000_2010, 1'b0);
    endtask

    task automatic t_illegal_r9();
        run("R9", "unknown opcode", 6'h3F, 6'h20, 5'd0, 32'd5, 32'd7, 16'h1, 32'h0, 1'b1);
        run("R9", "unknown function", 6'h00, 6'h21, 5'd0, 32'd5, 32'd7, 16'h1, 32'h0, 1'b1);
        run("R9", "function 0x01", 6'h00, 6'h01, 5'd2, 32'hFFFF_FFFF, 32'd7, 16'h1, 32'h0, 1'b1);
        run("R9", "branch opcode", 6'h04, 6'h00, 5'd0, 32'd5, 32'd7, 16'h1, 32'h0, 1'b1);
    endtask

    task automatic t_unused_r10();
        run("R10", "add ignores shamt", 6'h00, 6'h20, 5'd7, 32'd100, 32'd23, 16'hFFFF, 32'd123, 1'b0);
        run("R10", "sll ignores B", 6'h00, 6'h00, 5'd8, 32'h0000_00AB, 32'hFFFF_FFFF, 16'hFFFF, 32'h0000_AB00, 1'b0);
        run("R10", "mul ignores shamt", 6'h00, 6'h18, 5'd31, 32'd6, 32'd7, 16'h0, 32'd42, 1'b0);
    endtask

    // Print the single summary line once
    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    endtask

    // Main sequence
    initial begin
        n_checks = 0; n_fails = 0; done = 1'b0;
        rst_n = 1'b0;
        opcode = '0; funct = '0; shamt = '0; op_a = '0; op_b = '0; imm = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        t_reset_state();
        t_add_r1();
        t_sub_r2();
        t_mul_r3();
        t_logic_r4();
        t_sll_r5();
        t_srl_r6();
        t_addi_r7();
        t_addr_r8();
        t_illegal_r9();
        t_unused_r10();
        finish_run();
    end

    // Watchdog
    initial begin
        #(10 * 5000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule